// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write front end of a byte-wide non-volatile memory model. Byte writes arrive on a parallel bus made of three active-low strobes (chip select, output enable, write enable), a 15-bit address and an 8-bit data bus. The bus is sampled by a free-running clock. A write strobe is qualified, filtered against glitches, and turned into one byte event. The event's address is taken when the strobe opens and its data when the strobe closes. Bytes go into a page buffer of 64 bytes. Address bits 14:6 name the page and bits 5:0 name the byte inside it.

The first byte opens a page operation and starts a load window. Each further byte from the same page restarts the window. A byte that names a different page cancels the whole operation and nothing is written. When the window runs out, the block is busy for a fixed program time. It then copies every loaded byte into a behavioural array, one buffer slot per cycle. While the block is busy, the bus is ignored. A read port returns the array byte at the current address, one clock later.

The sequencer has four states:
- `ST_IDLE`: waiting for a first byte. A byte event takes it to `ST_LOAD`.
- `ST_LOAD`: the window is open. A same-page byte stays in `ST_LOAD` and restarts the window. A foreign-page byte goes back to `ST_IDLE` and cancels. Window expiry goes to `ST_PROG`.
- `ST_PROG`: the program timer runs. Its expiry goes to `ST_COMMIT`.
- `ST_COMMIT`: the loaded slots are written to the array. The last slot goes back to `ST_IDLE`.

Top module: `pwl_ctrl`

## Requirements
- R1: A write strobe exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold together. With `oe_n`=0 the block accepts no byte: `load_open` stays 0 and the array is unchanged.
- R2: A byte's address is the value of `addr` in the first sampled cycle of the strobe. Its data is the value of `din` in the last sampled cycle of the strobe.
- R3: A strobe that lasts fewer than `GLITCH_CYC` sampled cycles is ignored. No window opens and nothing is written.
- R4: After reset, `busy` and `load_open` are 0. An accepted byte in idle raises `load_open`. Programming does not begin before `LOAD_CYC` cycles have passed without a new byte.
- R5: Each accepted byte with the same page bits (14:6) as the open operation restarts the load window.
- R6: When the window expires, `load_open` falls and `busy` is high for at least `PROG_CYC` cycles. After `busy` falls, the loaded bytes read back from the array. `busy` and `load_open` are never high together.
- R7: Strobes that occur while `busy` is high are ignored. Their bytes are never written, and no new window opens from them.
- R8: A byte whose page bits differ from those of the open operation cancels it. The buffered bytes and the foreign byte are discarded, `load_open` falls, and no program cycle follows.
- R9: Only loaded byte positions are written. Other bytes of the page keep their old contents. If one offset is written twice, the later data is kept.
- R10: After reset every array byte reads 0xFF.
- R11: `dout` shows the array byte at `addr[ARRAY_AW-1:0]` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; must be high for a write |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address; bits 14:6 page, bits 5:0 offset |
| din | input | 8 | Write data |
| dout | output | 8 | Array byte at the current address, registered |
| busy | output | 1 | Program cycle or array commit in progress |
| load_open | output | 1 | Page load window is open |

## Verification
Some properties are checked on every cycle:
- `busy` and `load_open` are never high together.
- The array is written only while the block is busy.
- A load window opens only after a byte event.
- A program cycle starts only from an open window.
- A byte event follows only a qualified strobe of at least `GLITCH_CYC` cycles.

Other behaviour can only be shown by the bench scenarios, because it depends on values:
- which address and data edges are captured;
- that the window restarts;
- that a foreign-page byte cancels the operation;
- that untouched bytes of a page are preserved;
- that bytes written while busy are dropped.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
    localparam int BUS_AW   = 15;
    localparam int BUS_DW   = 8;
    localparam int OFS_W    = 6;
    localparam int PAGE_W   = BUS_AW - OFS_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG,
        ST_COMMIT
    } seq_state_t;
endpackage

// File: rtl/pwl_strobe.sv
// Qualifies the combined write strobe, rejects short pulses and emits a
// one-cycle byte event carrying the opening address and closing data.
module pwl_strobe #(
    parameter int GLITCH_CYC = 2,
    parameter int AW         = 15,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          evt,
    output logic [AW-1:0] evt_addr,
    output logic [DW-1:0] evt_data
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] G_LIM = CW'(GLITCH_CYC);

    logic          raw;
    logic [CW-1:0] run;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;

    assign raw = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= '0;
            evt      <= 1'b0;
            a_q      <= '0;
            d_q      <= '0;
            evt_addr <= '0;
            evt_data <= '0;
        end else begin
            evt <= 1'b0;
            if (raw) begin
                if (run == '0) a_q <= addr;
                d_q <= din;
                if (run < G_LIM) run <= run + 1'b1;
            end else begin
                if (run >= G_LIM) begin
                    evt      <= 1'b1;
                    evt_addr <= a_q;
                    evt_data <= d_q;
                end
                run <= '0;
            end
        end
    end
endmodule

// File: rtl/pwl_buffer.sv
// Page buffer: one data byte and one loaded flag per offset.
module pwl_buffer #(
    parameter int OFS_W = 6,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFS_W-1:0] wofs,
    input  logic [DW-1:0]    wdata,
    input  logic             clr,
    input  logic [OFS_W-1:0] rofs,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    localparam int SLOTS = 1 << OFS_W;

    logic [DW-1:0] slot_d [SLOTS];
    logic [SLOTS-1:0] slot_v;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[i] <= 1'b0;
                slot_d[i] <= '0;
            end else if (clr) begin
                slot_v[i] <= 1'b0;
            end else if (we && wofs == OFS_W'(i)) begin
                slot_v[i] <= 1'b1;
                slot_d[i] <= wdata;
            end
        end
    end

    assign rdata  = slot_d[rofs];
    assign rvalid = slot_v[rofs];
endmodule

// File: rtl/pwl_seq.sv
// Page operation sequencer: load window, program timer and commit walk.
module pwl_seq
    import pwl_pkg::*;
#(
    parameter int LOAD_CYC   = 30000,
    parameter int PROG_CYC   = 1000000,
    parameter int PG_W       = 9,
    parameter int OFS_W      = 6,
    parameter int ARR_PAGE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt,
    input  logic [PG_W-1:0]       evt_page,
    output logic                  buf_we,
    output logic                  buf_clr,
    output logic                  commit_en,
    output logic [OFS_W-1:0]      cidx,
    output logic [ARR_PAGE_W-1:0] mem_page,
    output logic                  busy,
    output logic                  load_open
);
    localparam int TMAX = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LOAD_RST = TW'(LOAD_CYC - 1);
    localparam logic [TW-1:0] PROG_RST = TW'(PROG_CYC - 1);
    localparam logic [OFS_W-1:0] LAST = '1;

    seq_state_t       state, nxt;
    logic [TW-1:0]    tcnt;
    logic [PG_W-1:0]  page_q;
    logic             match;

    assign match = (evt_page == page_q);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (evt) nxt = ST_LOAD;
            ST_LOAD: begin
                if (evt && !match)   nxt = ST_IDLE;
                else if (evt)        nxt = ST_LOAD;
                else if (tcnt == '0) nxt = ST_PROG;
            end
            ST_PROG:   if (tcnt == '0) nxt = ST_COMMIT;
            ST_COMMIT: if (cidx == LAST) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt   <= '0;
            page_q <= '0;
            cidx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (evt) begin
                    tcnt   <= LOAD_RST;
                    page_q <= evt_page;
                end
                ST_LOAD: begin
                    if (evt)              tcnt <= LOAD_RST;
                    else if (tcnt == '0)  tcnt <= PROG_RST;
                    else                  tcnt <= tcnt - 1'b1;
                end
                ST_PROG: begin
                    cidx <= '0;
                    if (tcnt != '0) tcnt <= tcnt - 1'b1;
                end
                ST_COMMIT: cidx <= cidx + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        buf_we    = 1'b0;
        buf_clr   = 1'b0;
        commit_en = 1'b0;
        busy      = 1'b0;
        load_open = 1'b0;
        unique case (state)
            ST_IDLE:   buf_we = evt;
            ST_LOAD: begin
                load_open = 1'b1;
                buf_we    = evt && match;
                buf_clr   = evt && !match;
            end
            ST_PROG:   busy = 1'b1;
            ST_COMMIT: begin
                busy      = 1'b1;
                commit_en = 1'b1;
                buf_clr   = (cidx == LAST);
            end
            default: ;
        endcase
    end

    assign mem_page = page_q[ARR_PAGE_W-1:0];
endmodule

// File: rtl/pwl_array.sv
// Behavioural byte array, erased to all ones on reset, registered read.
module pwl_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '1;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
    import pwl_pkg::*;
#(
    parameter int LOAD_CYC   = 30000,
    parameter int PROG_CYC   = 1000000,
    parameter int GLITCH_CYC = 2,
    parameter int ARRAY_AW   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] din,
    output logic [BUS_DW-1:0] dout,
    output logic              busy,
    output logic              load_open
);
    localparam int ARR_PAGE_W = ARRAY_AW - OFS_W;

    logic                  s_evt;
    logic [BUS_AW-1:0]     s_addr;
    logic [BUS_DW-1:0]     s_data;
    logic                  buf_we, buf_clr, commit_en, b_valid, mem_we;
    logic [OFS_W-1:0]      cidx;
    logic [BUS_DW-1:0]     b_data;
    logic [ARR_PAGE_W-1:0] mem_page;

    pwl_strobe #(.GLITCH_CYC(GLITCH_CYC), .AW(BUS_AW), .DW(BUS_DW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din),
        .evt(s_evt), .evt_addr(s_addr), .evt_data(s_data)
    );

    pwl_seq #(
        .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .PG_W(PAGE_W),
        .OFS_W(OFS_W), .ARR_PAGE_W(ARR_PAGE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .evt(s_evt),
        .evt_page(s_addr[BUS_AW-1:OFS_W]),
        .buf_we(buf_we), .buf_clr(buf_clr), .commit_en(commit_en),
        .cidx(cidx), .mem_page(mem_page), .busy(busy), .load_open(load_open)
    );

    pwl_buffer #(.OFS_W(OFS_W), .DW(BUS_DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .wofs(s_addr[OFS_W-1:0]),
        .wdata(s_data), .clr(buf_clr), .rofs(cidx),
        .rdata(b_data), .rvalid(b_valid)
    );

    assign mem_we = commit_en && b_valid;

    pwl_array #(.AW(ARRAY_AW), .DW(BUS_DW)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr({mem_page, cidx}),
        .wdata(b_data), .raddr(addr[ARRAY_AW-1:0]), .rdata(dout)
    );
endmodule

// File: rtl/pwl_ctrl_chk.sv
module pwl_ctrl_chk #(
    parameter int GLITCH_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic busy,
    input logic load_open,
    input logic wr_evt,
    input logic mem_we
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] G_LIM = CW'(GLITCH_CYC);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                        run_q <= '0;
        else if (!ce_n && !we_n && oe_n) begin
            if (run_q < G_LIM) run_q <= run_q + 1'b1;
        end else                           run_q <= '0;
    end

    p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && load_open));

    p_write_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_open_from_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_open) |-> $past(wr_evt));

    p_prog_from_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load_open));

    p_glitch_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |-> ($past(run_q) >= G_LIM));
endmodule

bind pwl_ctrl pwl_ctrl_chk #(.GLITCH_CYC(GLITCH_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .load_open(load_open), .wr_evt(s_evt), .mem_we(mem_we)
);

// File: tb/pwl_ctrl_tb.sv
`timescale 1ns/1ps
module pwl_ctrl_tb;
    localparam int LOAD_CYC = 40;
    localparam int PROG_CYC = 60;
    localparam int GLITCH   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        busy, load_open;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwl_ctrl #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC),
               .GLITCH_CYC(GLITCH), .ARRAY_AW(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy), .load_open(load_open)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        cyc(hold);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(2);
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        cyc(2);
        d = dout;
    endtask

    task automatic wait_commit(input string req);
        int t = 0;
        while (!busy && t < 300) begin cyc(1); t++; end
        check({req, " busy rises"}, busy, 1'b1);
        t = 0;
        while (busy && t < 400) begin cyc(1); t++; end
        check({req, " busy length"}, (t >= PROG_CYC) && !busy, 1'b1);
        cyc(1);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R4 reset busy", busy, 1'b0);
        check("R4 reset load_open", load_open, 1'b0);
        rd(15'h005, d); check("R10 erased 005", d, 8'hFF);
        rd(15'h3FF, d); check("R10 erased 3FF", d, 8'hFF);
    endtask

    task automatic t_single;
        logic [7:0] d;
        wr(15'h012, 8'h3C, 4);
        cyc(1);
        check("R4 window opens", load_open, 1'b1);
        cyc(25);
        check("R4 no early program", busy, 1'b0);
        wait_commit("R6 single");
        check("R6 window closed", load_open, 1'b0);
        rd(15'h012, d); check("R6 R11 single byte", d, 8'h3C);
        rd(15'h013, d); check("R9 neighbour kept", d, 8'hFF);
    endtask

    task automatic t_page;
        logic [7:0] d;
        wr(15'h040, 8'hA1, 3);
        wr(15'h041, 8'hB2, 3);
        wr(15'h07F, 8'hC3, 3);
        wr(15'h041, 8'hD4, 3);
        wait_commit("R6 page");
        rd(15'h040, d); check("R9 page byte 0", d, 8'hA1);
        rd(15'h041, d); check("R9 last write wins", d, 8'hD4);
        rd(15'h07F, d); check("R9 page byte 63", d, 8'hC3);
        rd(15'h042, d); check("R9 unloaded kept", d, 8'hFF);
    endtask

    task automatic t_restart;
        logic [7:0] d;
        wr(15'h0C5, 8'h11, 3);
        cyc(30);
        wr(15'h0C9, 8'h22, 3);
        cyc(25);
        check("R5 window restarted open", load_open, 1'b1);
        check("R5 window restarted not busy", busy, 1'b0);
        wait_commit("R5 restart");
        rd(15'h0C5, d); check("R5 first byte", d, 8'h11);
        rd(15'h0C9, d); check("R5 second byte", d, 8'h22);
    endtask

    task automatic t_cancel;
        logic [7:0] d;
        int seen = 0;
        wr(15'h080, 8'h55, 3);
        wr(15'h100, 8'h66, 3);
        cyc(1);
        check("R8 cancel closes window", load_open, 1'b0);
        for (int i = 0; i < LOAD_CYC + PROG_CYC + 20; i++) begin
            cyc(1);
            if (busy) seen = 1;
        end
        check("R8 no program after cancel", seen, 0);
        rd(15'h080, d); check("R8 first byte dropped", d, 8'hFF);
        rd(15'h100, d); check("R8 foreign byte dropped", d, 8'hFF);
    endtask

    task automatic t_oe_low;
        logic [7:0] d;
        @(negedge clk);
        addr = 15'h300; din = 8'h42; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        cyc(5);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        cyc(4);
        check("R1 oe low no window", load_open, 1'b0);
        cyc(LOAD_CYC + 10);
        check("R1 oe low no program", busy, 1'b0);
        rd(15'h300, d); check("R1 oe low array", d, 8'hFF);
    endtask

    task automatic t_glitch;
        logic [7:0] d;
        wr(15'h340, 8'h24, GLITCH - 1);
        cyc(2);
        check("R3 glitch no window", load_open, 1'b0);
        rd(15'h340, d); check("R3 glitch array", d, 8'hFF);
    endtask

    task automatic t_capture;
        logic [7:0] d;
        @(negedge clk);
        addr = 15'h1A5; din = 8'h01; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        cyc(2);
        addr = 15'h1B7; din = 8'h5A;
        cyc(2);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(2);
        wait_commit("R2 capture");
        rd(15'h1A5, d); check("R2 opening address closing data", d, 8'h5A);
        rd(15'h1B7, d); check("R2 late address unused", d, 8'hFF);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] d;
        int t = 0;
        wr(15'h200, 8'h77, 3);
        while (!busy && t < 300) begin cyc(1); t++; end
        wr(15'h205, 8'h99, 3);
        check("R7 still busy", busy, 1'b1);
        t = 0;
        while (busy && t < 400) begin cyc(1); t++; end
        cyc(2);
        check("R7 no window after busy", load_open, 1'b0);
        rd(15'h200, d); check("R7 first byte kept", d, 8'h77);
        rd(15'h205, d); check("R7 busy byte dropped", d, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_single();
        t_page();
        t_restart();
        t_cancel();
        t_oe_low();
        t_glitch();
        t_capture();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule